// File: doc/BRIEF.md
# Instruction-Set State and Fetch Alignment Controller

This block holds the processor's instruction-set state bit and updates it when control is transferred. The core supports two encodings. The wide encoding has 4-byte instructions aligned on 4-byte boundaries. The compact encoding has 2-byte and 4-byte instructions aligned on 2-byte boundaries. Both lengths of compact instruction execute in the compact state, so the state never changes between them. The state register is the compact-state flag (status bit 5). A second status flag for a third execution state is driven as a constant 0. The core is in compact state exactly when the compact flag is 1 and that second flag is 0.

The execute stage presents one transfer event per cycle. An event carries a target address and a class code. Only four classes may change state: a branch through a register, a branch-with-link through a register, a single-word load into the PC, and a multiple-register load that includes the PC. For these classes, bit 0 of the target picks the new state. A value of 1 selects compact and 0 selects wide. A plain PC write keeps the present state. After every accepted event the block presents a fetch address aligned for the resulting state, one cycle later. It also raises an alignment-fault pulse when a transfer into wide state names a target that is only halfword aligned. The reset state comes from an input, so a core that only runs compact code can start in compact state.

Top module: `isa_state_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `compact_o` equals `rst_compact_i`, and `fetch_addr_o`, `fetch_valid_o` and `align_fault_o` are all 0.
- R2: An event with `xfer_valid_i`=1 and a class code of 2 (register branch), 3 (register branch with link), 4 (single load to PC) or 5 (multiple load with PC) sets `compact_o` to bit 0 of `target_i` on the next cycle.
- R3: When a state-changing event selects compact state, the next cycle's `fetch_addr_o` is the target with bit 0 cleared.
- R4: When a state-changing event selects wide state, the next cycle's `fetch_addr_o` is the target with bits [1:0] cleared.
- R5: A state-changing event that selects wide state with target bit 1 set drives `align_fault_o` high for exactly one cycle, the cycle after the event. No other event raises it.
- R6: An event with class code 1 (plain PC write) leaves `compact_o` unchanged. Its fetch address is the target aligned for the current state (bit 0 cleared in compact, bits [1:0] cleared in wide), and it raises no fault.
- R7: `jstate_o` is 0 at all times.
- R8: With `xfer_valid_i`=0, or with class code 0, 6 or 7, `compact_o` and `fetch_addr_o` hold their values and `fetch_valid_o` is 0 on the next cycle.
- R9: `fetch_valid_o` is high for one cycle, one cycle after each event of class 1 to 5.
- R10: Consecutive state-changing events whose targets have bit 0 set keep `compact_o` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_compact_i | input | 1 | State loaded at reset (1 = compact) |
| xfer_valid_i | input | 1 | Transfer event present this cycle |
| xfer_kind_i | input | 3 | Transfer class code |
| target_i | input | ADDR_W | Transfer target address |
| compact_o | output | 1 | Compact-state status flag (bit 5) |
| jstate_o | output | 1 | Third-state status flag, always 0 |
| fetch_addr_o | output | ADDR_W | Aligned next fetch address |
| fetch_valid_o | output | 1 | Fetch address updated this cycle |
| align_fault_o | output | 1 | Halfword-aligned wide-state target |

## Verification
The bench builds the block with the default 32-bit address width. This lets the all-ones target and the top-bit-only target show that masking touches only the low bits and leaves the upper address intact. Both reset values of `rst_compact_i` are applied. That covers a plain PC write whose alignment rule comes from the state held across reset and not from the target. It also covers the one-cycle life of the fault pulse and the unused class codes that must leave the state alone.

// File: rtl/isa_state_pkg.sv
package isa_state_pkg;
  typedef enum logic [2:0] {
    XK_NONE    = 3'd0,
    XK_PCWRITE = 3'd1,
    XK_BRREG   = 3'd2,
    XK_BRLINK  = 3'd3,
    XK_LDONE   = 3'd4,
    XK_LDMULTI = 3'd5,
    XK_RSVD6   = 3'd6,
    XK_RSVD7   = 3'd7
  } xfer_kind_e;
endpackage

// File: rtl/isa_xfer_classify.sv
module isa_xfer_classify
  import isa_state_pkg::*;
(
  input  logic       valid_i,
  input  logic [2:0] kind_i,
  output logic       accept_o,
  output logic       switch_o
);
  xfer_kind_e kind;

  always_comb begin
    kind     = xfer_kind_e'(kind_i);
    accept_o = 1'b0;
    switch_o = 1'b0;
    if (valid_i) begin
      unique case (kind)
        XK_PCWRITE: accept_o = 1'b1;
        XK_BRREG, XK_BRLINK, XK_LDONE, XK_LDMULTI: begin
          accept_o = 1'b1;
          switch_o = 1'b1;
        end
        default: accept_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/isa_fetch_align.sv
module isa_fetch_align #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] target_i,
  input  logic              cur_compact_i,
  input  logic              switch_i,
  output logic              next_compact_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              fault_o
);
  localparam int HI = ADDR_W - 1;

  always_comb begin
    next_compact_o = switch_i ? target_i[0] : cur_compact_i;
    if (next_compact_o) begin
      addr_o = {target_i[HI:1], 1'b0};
    end else begin
      addr_o = {target_i[HI:2], 2'b00};
    end
    fault_o = switch_i && !target_i[0] && target_i[1];
  end
endmodule

// File: rtl/isa_state_ctrl.sv
module isa_state_ctrl #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rst_compact_i,
  input  logic              xfer_valid_i,
  input  logic [2:0]        xfer_kind_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic              compact_o,
  output logic              jstate_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic              fetch_valid_o,
  output logic              align_fault_o
);
  logic              accept;
  logic              do_switch;
  logic              next_compact;
  logic [ADDR_W-1:0] next_addr;
  logic              next_fault;

  isa_xfer_classify u_classify (
    .valid_i  (xfer_valid_i),
    .kind_i   (xfer_kind_i),
    .accept_o (accept),
    .switch_o (do_switch)
  );

  isa_fetch_align #(.ADDR_W(ADDR_W)) u_align (
    .target_i       (target_i),
    .cur_compact_i  (compact_o),
    .switch_i       (do_switch),
    .next_compact_o (next_compact),
    .addr_o         (next_addr),
    .fault_o        (next_fault)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      compact_o     <= rst_compact_i;
      fetch_addr_o  <= '0;
      fetch_valid_o <= 1'b0;
      align_fault_o <= 1'b0;
    end else begin
      fetch_valid_o <= accept;
      align_fault_o <= accept && next_fault;
      if (accept) begin
        compact_o    <= next_compact;
        fetch_addr_o <= next_addr;
      end
    end
  end

  assign jstate_o = 1'b0;
endmodule

// File: rtl/isa_state_ctrl_chk.sv
module isa_state_ctrl_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              xfer_valid_i,
  input logic [2:0]        xfer_kind_i,
  input logic [ADDR_W-1:0] target_i,
  input logic              compact_o,
  input logic [ADDR_W-1:0] fetch_addr_o,
  input logic              fetch_valid_o,
  input logic              align_fault_o
);
  logic is_switch, is_write, is_none;
  assign is_switch = xfer_valid_i && (xfer_kind_i >= 3'd2) && (xfer_kind_i <= 3'd5);
  assign is_write  = xfer_valid_i && (xfer_kind_i == 3'd1);
  assign is_none   = !is_switch && !is_write;

  a_r2_state_from_bit0: assert property (@(posedge clk) disable iff (rst)
    is_switch |=> compact_o == $past(target_i[0]));

  a_r3_compact_halfword: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid_o && compact_o) |-> fetch_addr_o[0] == 1'b0);

  a_r4_wide_word: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid_o && !compact_o) |-> fetch_addr_o[1:0] == 2'b00);

  a_r5_fault_only_wide: assert property (@(posedge clk) disable iff (rst)
    align_fault_o |-> (!compact_o && fetch_valid_o));

  a_r5_fault_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (align_fault_o && is_none) |=> !align_fault_o);

  a_r6_write_keeps_state: assert property (@(posedge clk) disable iff (rst)
    is_write |=> ($stable(compact_o) && !align_fault_o));

  a_r8_idle_holds: assert property (@(posedge clk) disable iff (rst)
    is_none |=> (!fetch_valid_o && $stable(compact_o) && $stable(fetch_addr_o)));

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
    (is_switch || is_write) |=> fetch_valid_o);
endmodule

bind isa_state_ctrl isa_state_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .xfer_valid_i  (xfer_valid_i),
  .xfer_kind_i   (xfer_kind_i),
  .target_i      (target_i),
  .compact_o     (compact_o),
  .fetch_addr_o  (fetch_addr_o),
  .fetch_valid_o (fetch_valid_o),
  .align_fault_o (align_fault_o)
);

// File: tb/isa_state_ctrl_bench.sv
`timescale 1ns/1ps
module isa_state_ctrl_bench;
  localparam int AW = 32;
  localparam int NV = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rst_compact_i = 1'b0;
  logic          xfer_valid_i = 1'b0;
  logic [2:0]    xfer_kind_i = 3'd0;
  logic [AW-1:0] target_i = '0;
  logic          compact_o, jstate_o, fetch_valid_o, align_fault_o;
  logic [AW-1:0] fetch_addr_o;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  isa_state_ctrl #(.ADDR_W(AW)) u_isa_state_ctrl (
    .clk(clk), .rst(rst), .rst_compact_i(rst_compact_i),
    .xfer_valid_i(xfer_valid_i), .xfer_kind_i(xfer_kind_i), .target_i(target_i),
    .compact_o(compact_o), .jstate_o(jstate_o), .fetch_addr_o(fetch_addr_o),
    .fetch_valid_o(fetch_valid_o), .align_fault_o(align_fault_o)
  );

  // {kind, target, expected compact, expected fetch address, expected fault}
  localparam logic [68:0] VEC [NV] = '{
    {3'd2, 32'h0000_1001, 1'b1, 32'h0000_1000, 1'b0},
    {3'd3, 32'h0000_2003, 1'b1, 32'h0000_2002, 1'b0},
    {3'd1, 32'h0000_3007, 1'b1, 32'h0000_3006, 1'b0},
    {3'd4, 32'h0000_4002, 1'b0, 32'h0000_4000, 1'b1},
    {3'd1, 32'h0000_5007, 1'b0, 32'h0000_5004, 1'b0},
    {3'd5, 32'h0000_6004, 1'b0, 32'h0000_6004, 1'b0},
    {3'd5, 32'hFFFF_FFFF, 1'b1, 32'hFFFF_FFFE, 1'b0},
    {3'd4, 32'h8000_0000, 1'b0, 32'h8000_0000, 1'b0}
  };

  task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] k, input logic [AW-1:0] t);
    xfer_valid_i = 1'b1; xfer_kind_i = k; target_i = t;
    @(negedge clk);
    xfer_valid_i = 1'b0; xfer_kind_i = 3'd0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset into wide state
    repeat (3) @(negedge clk);
    chk("R1", {29'd0, compact_o, fetch_valid_o, align_fault_o}, '0);
    chk("R1", fetch_addr_o, '0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", {31'd0, compact_o}, '0);
    chk("R7", {31'd0, jstate_o}, '0);

    // R2 R3 R4 R5 R6 R9 R10: table walk
    for (int i = 0; i < NV; i++) begin
      send(VEC[i][68:66], VEC[i][65:34]);
      chk("R2", {31'd0, compact_o}, {31'd0, VEC[i][33]});
      chk(VEC[i][33] ? "R3" : "R4", fetch_addr_o, VEC[i][32:1]);
      chk("R5", {31'd0, align_fault_o}, {31'd0, VEC[i][0]});
      chk("R9", {31'd0, fetch_valid_o}, 32'd1);
      chk("R7", {31'd0, jstate_o}, '0);
    end

    // R5: fault lasts one cycle only
    send(3'd2, 32'h0000_0A0A);
    chk("R5", {31'd0, align_fault_o}, 32'd1);
    @(negedge clk);
    chk("R5", {31'd0, align_fault_o}, '0);
    chk("R9", {31'd0, fetch_valid_o}, '0);

    // R8: reserved codes and idle ignored (now in wide state, addr 0x0A08)
    for (int k = 0; k < 8; k += 6) begin
      send(3'(k), 32'h0000_7771);
      chk("R8", {31'd0, compact_o}, '0);
      chk("R8", fetch_addr_o, 32'h0000_0A08);
      chk("R8", {31'd0, fetch_valid_o}, '0);
    end
    send(3'd7, 32'h0000_7771);
    chk("R8", {31'd0, compact_o}, '0);
    chk("R8", fetch_addr_o, 32'h0000_0A08);
    target_i = 32'h0000_1235; xfer_kind_i = 3'd2; xfer_valid_i = 1'b0;
    @(negedge clk);
    chk("R8", {31'd0, compact_o}, '0);
    chk("R8", {31'd0, fetch_valid_o}, '0);
    xfer_kind_i = 3'd0;

    // R1: reset into compact state, then R6 PC write uses compact alignment
    rst = 1'b1; rst_compact_i = 1'b1;
    @(negedge clk);
    chk("R1", {31'd0, compact_o}, 32'd1);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", {31'd0, compact_o}, 32'd1);
    send(3'd1, 32'h0000_0FFE);
    chk("R6", {31'd0, compact_o}, 32'd1);
    chk("R6", fetch_addr_o, 32'h0000_0FFE);
    chk("R6", {31'd0, align_fault_o}, '0);
    chk("R7", {31'd0, jstate_o}, '0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule